// File: doc/BRIEF.md
# Inter-Processor Interrupt Command Issuer

This block is the command register pair of a per-processor interrupt unit. Software composes an inter-processor interrupt by writing two 32-bit words. The upper word, at offset 0x310, holds the destination. The lower word, at offset 0x300, holds the vector, the kind of delivery, the addressing mode, the level and trigger bits and a destination shorthand. Writing the upper word only stores it. Writing the lower word stores it and launches one message on a valid/ready output. Software therefore writes the upper word first.

The outgoing message carries a destination bitmap with one bit per processor, the vector, the delivery kind and the level and trigger bits. The bitmap is formed when the message launches. A nonzero shorthand sets it to this processor alone, to all processors, or to all processors except this one, and the stored destination is then ignored. With shorthand zero, physical mode sets the single bit selected by the destination ID, and logical mode uses the destination byte as a flat mask. A delivery-status bit in the lower word reads one from launch until the receiver takes the message.

The block has a two-state controller. In `ST_IDLE` no message is outstanding. The transition `LAUNCH` (a lower-word write while idle) moves it to `ST_PEND`. In `ST_PEND` the message is held on the output with status set. The transition `ACCEPT` (ready seen while valid) returns it to `ST_IDLE`. When ready is low in `ST_PEND`, the transition `STALL` keeps the state unchanged.

Top module: `ipi_cmd_issuer`

## Requirements
- R1: After reset, msg_valid is 0 and both command registers read as zero, including the delivery-status bit (bit 12 of offset 0x300).
- R2: A write to offset 0x310 launches no message. On read-back it returns the written bits 31:24 with bits 23:0 as zero.
- R3: A write to offset 0x300 while status is clear raises msg_valid on the following cycle and makes bit 12 read as 1. The message then carries the fields written: vector = bits 7:0, delivery kind = bits 10:8, logical = bit 11, level = bit 14, trigger = bit 15.
- R4: msg_valid and all message fields hold steady while msg_ready is low. msg_valid and the status bit clear in the cycle after the edge at which msg_valid and msg_ready are both high.
- R5: A write to offset 0x300 while the status bit is set is ignored. It does not change the stored command or start another message.
- R6: With shorthand (bits 19:18) equal to 0 and bit 11 clear, msg_dest has exactly bit ID set, where ID is bits 27:24 of offset 0x310. When ID is NUM_CPU or more, msg_dest is all zero and the message still completes the handshake.
- R7: With shorthand 0 and bit 11 set, msg_dest bit i equals bit 24+i of offset 0x310.
- R8: Shorthand 1 gives a msg_dest with only bit my_id set, whatever the destination register holds.
- R9: Shorthand 2 gives a msg_dest with every bit set.
- R10: Shorthand 3 gives a msg_dest with every bit set except bit my_id.
- R11: Reserved bits read as zero: bits 13, 17:16 and 31:20 at offset 0x300, and bits 23:0 at offset 0x310. Any other offset reads zero.
- R12: msg_dest is captured at launch. A write to offset 0x310 while a message is pending does not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| my_id | input | ID_W | Static ID of this processor |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte offset for write and read |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for addr (combinational) |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Receiver takes the message |
| msg_dest | output | NUM_CPU | Destination bitmap |
| msg_vector | output | 8 | Interrupt vector or start page |
| msg_mode | output | 3 | Delivery kind |
| msg_logical | output | 1 | Logical addressing flag |
| msg_level | output | 1 | Level bit |
| msg_trigger | output | 1 | Trigger bit |

## Verification
The properties assume that msg_ready is a clean level sampled at the clock edge, that addr stays stable while wr_en is high, and that my_id does not change after reset. The bench changes wr_en, addr and msg_ready only a short time after a rising edge and holds them for a whole cycle. It sets my_id once, before reset is released. Pending-state writes are issued only while ready is held low, so that the ignored-write and captured-destination properties are exercised before acceptance.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    localparam int LO_OFFSET = 12'h300;
    localparam int HI_OFFSET = 12'h310;
    localparam int DEST_W    = 8;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_PEND = 1'b1
    } ipi_state_e;

    typedef enum logic [1:0] {
        SH_NONE   = 2'd0,
        SH_SELF   = 2'd1,
        SH_ALL    = 2'd2,
        SH_OTHERS = 2'd3
    } ipi_short_e;

    typedef struct packed {
        logic [1:0] shorthand;
        logic       trigger;
        logic       level;
        logic       logical;
        logic [2:0] mode;
        logic [7:0] vector;
    } ipi_cmd_lo_t;

    function automatic ipi_cmd_lo_t unpack_lo(input logic [31:0] w);
        ipi_cmd_lo_t c;
        c.vector    = w[7:0];
        c.mode      = w[10:8];
        c.logical   = w[11];
        c.level     = w[14];
        c.trigger   = w[15];
        c.shorthand = w[19:18];
        return c;
    endfunction

endpackage

// File: rtl/ipi_cmd_regs.sv
module ipi_cmd_regs
    import ipi_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wr_data,
    input  logic              busy,
    output logic              launch,
    output ipi_cmd_lo_t       cmd_lo,
    output logic [DEST_W-1:0] dest_field,
    output logic [31:0]       rd_data
);

    localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(LO_OFFSET);
    localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(HI_OFFSET);

    logic hi_write;

    assign launch   = wr_en && (addr == LO_ADDR) && !busy;
    assign hi_write = wr_en && (addr == HI_ADDR);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_lo     <= '0;
            dest_field <= '0;
        end else begin
            if (launch)   cmd_lo     <= unpack_lo(wr_data);
            if (hi_write) dest_field <= wr_data[31:24];
        end
    end

    always_comb begin
        rd_data = '0;
        if (addr == LO_ADDR) begin
            rd_data = {12'd0, cmd_lo.shorthand, 2'd0, cmd_lo.trigger, cmd_lo.level,
                       1'b0, busy, cmd_lo.logical, cmd_lo.mode, cmd_lo.vector};
        end else if (addr == HI_ADDR) begin
            rd_data = {dest_field, 24'd0};
        end
    end

endmodule

// File: rtl/ipi_dest_decode.sv
module ipi_dest_decode
    import ipi_pkg::*;
#(
    parameter int NUM_CPU = 8,
    parameter int ID_W    = 4
) (
    input  logic [1:0]         shorthand,
    input  logic               logical,
    input  logic [DEST_W-1:0]  dest_field,
    input  logic [ID_W-1:0]    my_id,
    output logic [NUM_CPU-1:0] bitmap
);

    logic [ID_W-1:0]    target_id;
    logic [NUM_CPU-1:0] explicit_map;
    logic [NUM_CPU-1:0] self_map;

    assign target_id = dest_field[ID_W-1:0];

    for (genvar i = 0; i < NUM_CPU; i++) begin : g_cpu
        assign self_map[i] = (my_id == ID_W'(i));
        if (i < DEST_W) begin : g_flat
            assign explicit_map[i] = logical ? dest_field[i] : (target_id == ID_W'(i));
        end else begin : g_phys
            assign explicit_map[i] = !logical && (target_id == ID_W'(i));
        end
    end

    always_comb begin
        unique case (ipi_short_e'(shorthand))
            SH_NONE:   bitmap = explicit_map;
            SH_SELF:   bitmap = self_map;
            SH_ALL:    bitmap = '1;
            SH_OTHERS: bitmap = ~self_map;
            default:   bitmap = '0;
        endcase
    end

endmodule

// File: rtl/ipi_issue_fsm.sv
module ipi_issue_fsm
    import ipi_pkg::*;
#(
    parameter int NUM_CPU = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               launch,
    input  logic [NUM_CPU-1:0] next_dest,
    input  logic               msg_ready,
    output logic               msg_valid,
    output logic               busy,
    output logic [NUM_CPU-1:0] msg_dest
);

    ipi_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            msg_dest <= '0;
        end else begin
            state <= state_nx;
            if (launch) msg_dest <= next_dest;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (launch)    state_nx = ST_PEND;
            ST_PEND: if (msg_ready) state_nx = ST_IDLE;
            default:                state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        msg_valid = 1'b0;
        busy      = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_PEND: begin
                msg_valid = 1'b1;
                busy      = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ipi_cmd_issuer.sv
module ipi_cmd_issuer
    import ipi_pkg::*;
#(
    parameter int NUM_CPU = 8,
    parameter int ID_W    = 4,
    parameter int ADDR_W  = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ID_W-1:0]    my_id,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [31:0]        wr_data,
    output logic [31:0]        rd_data,
    output logic               msg_valid,
    input  logic               msg_ready,
    output logic [NUM_CPU-1:0] msg_dest,
    output logic [7:0]         msg_vector,
    output logic [2:0]         msg_mode,
    output logic               msg_logical,
    output logic               msg_level,
    output logic               msg_trigger
);

    logic               launch;
    logic               busy;
    ipi_cmd_lo_t        cmd_lo;
    ipi_cmd_lo_t        incoming;
    logic [DEST_W-1:0]  dest_field;
    logic [NUM_CPU-1:0] next_dest;

    assign incoming = unpack_lo(wr_data);

    ipi_cmd_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wr_data    (wr_data),
        .busy       (busy),
        .launch     (launch),
        .cmd_lo     (cmd_lo),
        .dest_field (dest_field),
        .rd_data    (rd_data)
    );

    ipi_dest_decode #(.NUM_CPU(NUM_CPU), .ID_W(ID_W)) u_dec (
        .shorthand  (incoming.shorthand),
        .logical    (incoming.logical),
        .dest_field (dest_field),
        .my_id      (my_id),
        .bitmap     (next_dest)
    );

    ipi_issue_fsm #(.NUM_CPU(NUM_CPU)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .next_dest  (next_dest),
        .msg_ready  (msg_ready),
        .msg_valid  (msg_valid),
        .busy       (busy),
        .msg_dest   (msg_dest)
    );

    assign msg_vector  = cmd_lo.vector;
    assign msg_mode    = cmd_lo.mode;
    assign msg_logical = cmd_lo.logical;
    assign msg_level   = cmd_lo.level;
    assign msg_trigger = cmd_lo.trigger;

endmodule

// File: rtl/ipi_cmd_checker.sv
module ipi_cmd_checker #(
    parameter int NUM_CPU = 8,
    parameter int ADDR_W  = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  addr,
    input logic               msg_valid,
    input logic               msg_ready,
    input logic [NUM_CPU-1:0] msg_dest,
    input logic [7:0]         msg_vector,
    input logic [2:0]         msg_mode
);

    localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(ipi_pkg::LO_OFFSET);

    logic lo_write;
    assign lo_write = wr_en && (addr == LO_ADDR);

    a_r3_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_write && !msg_valid) |=> msg_valid);

    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!msg_valid && !lo_write) |=> !msg_valid);

    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=>
            (msg_valid && $stable(msg_dest) && $stable(msg_vector) && $stable(msg_mode)));

    a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_ready) |=> !msg_valid);

    a_r5_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && lo_write) |=> ($stable(msg_vector) && $stable(msg_mode)));

endmodule

bind ipi_cmd_issuer ipi_cmd_checker #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .msg_valid (msg_valid),
    .msg_ready (msg_ready),
    .msg_dest  (msg_dest),
    .msg_vector(msg_vector),
    .msg_mode  (msg_mode)
);

// File: tb/ipi_cmd_issuer_test.sv
module ipi_cmd_issuer_test;

    localparam int NUM_CPU = 8;
    localparam int ID_W    = 4;
    localparam int ADDR_W  = 12;
    localparam logic [ADDR_W-1:0] LO = 12'h300;
    localparam logic [ADDR_W-1:0] HI = 12'h310;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [ID_W-1:0]    my_id = 4'd2;
    logic               wr_en = 1'b0;
    logic [ADDR_W-1:0]  addr = '0;
    logic [31:0]        wr_data = '0;
    logic [31:0]        rd_data;
    logic               msg_valid;
    logic               msg_ready = 1'b0;
    logic [NUM_CPU-1:0] msg_dest;
    logic [7:0]         msg_vector;
    logic [2:0]         msg_mode;
    logic               msg_logical, msg_level, msg_trigger;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    typedef struct {
        logic [20:0] fields;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    ipi_cmd_issuer #(.NUM_CPU(NUM_CPU), .ID_W(ID_W), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .my_id(my_id), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_dest(msg_dest), .msg_vector(msg_vector),
        .msg_mode(msg_mode), .msg_logical(msg_logical), .msg_level(msg_level),
        .msg_trigger(msg_trigger)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_dest(input logic [31:0] hi, input logic [31:0] lo);
        logic [7:0] self_m;
        self_m = (my_id < NUM_CPU) ? 8'(1 << my_id) : 8'h00;
        case (lo[19:18])
            2'd1: return self_m;
            2'd2: return 8'hFF;
            2'd3: return ~self_m;
            default: begin
                if (lo[11]) return hi[31:24];
                return (hi[27:24] < NUM_CPU) ? 8'(1 << hi[27:24]) : 8'h00;
            end
        endcase
    endfunction

    function automatic logic [20:0] pack_exp(input logic [31:0] hi, input logic [31:0] lo);
        return {exp_dest(hi, lo), lo[7:0], lo[10:8], lo[11], lo[14], lo[15]};
    endfunction

    // Monitor: pops expected items on each handshake
    always @(negedge clk) begin
        if (rst_n && msg_valid && msg_ready) begin
            logic [20:0] act;
            act = {msg_dest, msg_vector, msg_mode, msg_logical, msg_level, msg_trigger};
            if (sb.size() == 0) begin
                check(0, "R3 unexpected message", 32'(act), 32'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(act == e.fields, e.tag, 32'(act), 32'(e.fields));
            end
        end
    end

    task automatic reg_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        wr_en = 1'b1; addr = a; wr_data = d;
        @(posedge clk); #2;
        wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(posedge clk); #2;
        addr = a;
        @(negedge clk);
        d = rd_data;
    endtask

    // Driver: full issue with ready already high
    task automatic issue(input logic [31:0] hi, input logic [31:0] lo, input string tag);
        exp_t e;
        reg_write(HI, hi);
        e.fields = pack_exp(hi, lo);
        e.tag = tag;
        sb.push_back(e);
        reg_write(LO, lo);
        @(negedge clk);
        check(msg_valid === 1'b1, {tag, " (R3 valid after launch)"}, 32'(msg_valid), 32'h1);
        @(negedge clk);
        check(msg_valid === 1'b0, {tag, " (R4 release)"}, 32'(msg_valid), 32'h0);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        logic [31:0] d;
        exp_t e;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        check(msg_valid === 1'b0, "R1 valid after reset", 32'(msg_valid), 32'h0);
        reg_read(LO, d); check(d === 32'h0, "R1 low word after reset", d, 32'h0);
        reg_read(HI, d); check(d === 32'h0, "R1 high word after reset", d, 32'h0);

        // R2 / R11 high write, no launch, reserved bits zero
        reg_write(HI, 32'hFFFF_FFFF);
        @(negedge clk);
        check(msg_valid === 1'b0, "R2 no message on high write", 32'(msg_valid), 32'h0);
        reg_read(HI, d); check(d === 32'hFF00_0000, "R2 R11 high read-back", d, 32'hFF00_0000);
        reg_read(12'h320, d); check(d === 32'h0, "R11 other offset", d, 32'h0);

        // R3 R5 R12 pending path with ready held low
        reg_write(HI, 32'h0300_0000);
        e.fields = pack_exp(32'h0300_0000, 32'h0000_4541);
        e.tag = "R3 R6 R12 physical id 3 message";
        sb.push_back(e);
        reg_write(LO, 32'hFFF3_6541 & 32'hFFF3_E7FF);
        @(negedge clk);
        check(msg_valid === 1'b1, "R3 valid one cycle after launch", 32'(msg_valid), 32'h1);
        reg_read(LO, d);
        check(d === 32'h0000_5541, "R3 R11 low read-back with status", d, 32'h0000_5541);
        reg_write(LO, 32'h0000_0099);
        reg_read(LO, d);
        check(d === 32'h0000_5541, "R5 busy write ignored", d, 32'h0000_5541);
        reg_write(HI, 32'h0500_0000);
        @(negedge clk);
        check(msg_dest === 8'h08, "R12 dest kept after high write", 32'(msg_dest), 32'h08);
        check(msg_valid === 1'b1, "R4 valid held while not ready", 32'(msg_valid), 32'h1);
        @(posedge clk); #2 msg_ready = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(msg_valid === 1'b0, "R4 valid clears after accept", 32'(msg_valid), 32'h0);
        reg_read(LO, d);
        check(d[12] === 1'b0, "R4 status clears after accept", 32'(d[12]), 32'h0);

        // R6 physical out-of-range ID
        issue(32'h0900_0000, 32'h0000_4020, "R6 id beyond range empty map");
        issue(32'h0700_0000, 32'h0000_4431, "R6 physical id 7");
        // R7 logical flat mask
        issue(32'hA500_0000, 32'h0000_4852, "R7 logical mask");
        // R8 R9 R10 shorthands ignore explicit destination
        issue(32'h0500_0000, 32'h0004_4063, "R8 self shorthand");
        issue(32'h0500_0000, 32'h0008_4074, "R9 all shorthand");
        issue(32'h0500_0000, 32'h000C_0585 | 32'h0000_8000, "R10 others shorthand, level 0 trigger 1");

        @(negedge clk);
        check(sb.size() == 0, "R3 every issued message delivered", 32'(sb.size()), 32'h0);
        done = 1;
        finish_run();
    end

endmodule